// File: doc/BRIEF.md
# Timer Configuration Register Bank with Write Lock

This block holds the configuration words of a timer/counter peripheral and presents them to the counter core as live signals. Software reaches it through a plain synchronous port: one write strobe, one read strobe, a word address, 32-bit write data with four byte strobes, and registered 32-bit read data. The bank holds a main control word, a drive word (per-channel inversion), a waveform word, an event word, and a set/clear address pair for the one-shot and count-direction bits.

Most configuration fields are locked while the peripheral runs. The lock is judged on the enable bit as it stood before the write. While enable is 1, a write to a locked word changes nothing. A control-word write reaches only its enable and soft-reset bits. A control-word write made while disabled that also sets enable applies all of its fields at once. A write that clears enable while running changes only the enable bit. Writing 1 to the soft-reset bit returns every register, enable included, to its reset value.

Top module: `tcfg_bank`

## Requirements
- R1: After reset every word reads 0, every configuration output is 0, and the count-mode output is code 0, which selects 16-bit counting.
- R2: While enable is 0, writes to the control, drive, waveform and event words update exactly the bytes whose strobe is 1. Bit layout: control word has soft-reset at bit 0, enable at 1, mode at 3:2, prescaler at 4 and up (PW bits), prescaler sync at 9:8 and capture enables at 16 and up (NCH bits). Drive has inversion at 0 and up (NCH bits). Waveform has its select at 1:0. Event has its action at 2:0, its input enable at 4 and its output enable at 5.
- R3: While enable is 1, writes leave every drive, waveform and event field and every locked control field unchanged.
- R4: A control write with byte 0 strobed, made while enable is 0 and with bit 1 set, applies its locked fields and sets enable in the same cycle.
- R5: A control write made while enable is 1 with bit 1 clear clears enable and leaves every locked field unchanged.
- R6: Enable is written from bit 1 of a control write whenever byte 0 is strobed, whatever its current value. A write without byte 0 strobed leaves enable alone.
- R7: A control write with byte 0 strobed and bit 0 set returns all registers to their reset values on that clock edge. This includes enable, one-shot and direction, and it overrides every other bit of the write. Bit 0 always reads back 0.
- R8: Mode codes are 0 = 16-bit, 1 = 8-bit and 2 = 32-bit. An accepted write that carries code 3 leaves the mode unchanged.
- R9: Bits outside the listed fields read 0. Addresses 6 and above read 0, and writes to them change nothing.
- R10: At address 4, a 1 in bit 0 sets one-shot and a 1 in bit 1 sets direction. At address 5 such 1s clear the bits. 0 bits leave them unchanged. Both addresses read back the current pair, and the lock never applies to them.
- R11: A read returns, on the clock edge after the read strobe, the contents of the addressed word, whether enable is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address: 0 control, 1 drive, 2 waveform, 3 event, 4 set, 5 clear |
| be | input | 4 | Byte strobes for the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| cfg_enable | output | 1 | Peripheral enable |
| cfg_mode | output | 2 | Counter width code |
| cfg_presc | output | PW | Prescaler select |
| cfg_presync | output | 2 | Prescaler synchronization select |
| cfg_capten | output | NCH | Per-channel capture enable |
| cfg_inven | output | NCH | Per-channel inversion |
| cfg_wavegen | output | 2 | Waveform generation select |
| cfg_evact | output | 3 | Event action select |
| cfg_evin_en | output | 1 | Event input enable |
| cfg_evout_en | output | 1 | Event output enable |
| cfg_oneshot | output | 1 | One-shot operation |
| cfg_dir | output | 1 | Count direction (1 = down) |

## Verification
The bench uses the default build: two channels, a 3-bit prescaler and a 4-bit address. At that size every combination of the four byte strobes can be swept over each locked word, in both enable states. That covers all partial-write and lock cases, and the mode code 3 appears in the sweep data. The 4-bit address also covers the full unmapped range. Directed sequences then cover the same-access enable and disable rules, soft reset that overrides other bits, and the set/clear pair under both enable states.

// File: rtl/tcfg_pkg.sv
// Package: shared constants and types for the timer configuration bank.
// Assumes word addressing and a 32-bit data path.
package tcfg_pkg;
    localparam int unsigned NREG       = 6;
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_DRIVE    = 1;
    localparam int unsigned A_WAVE     = 2;
    localparam int unsigned A_EVENT    = 3;
    localparam int unsigned A_CBSET    = 4;
    localparam int unsigned A_CBCLR    = 5;

    localparam int unsigned B_SWRST    = 0;
    localparam int unsigned B_EN       = 1;
    localparam int unsigned B_MODE     = 2;
    localparam int unsigned B_PRESC    = 4;
    localparam int unsigned B_SYNC     = 8;
    localparam int unsigned B_CAPT     = 16;

    typedef enum logic [1:0] {
        MODE_16  = 2'd0,
        MODE_8   = 2'd1,
        MODE_32  = 2'd2,
        MODE_BAD = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/tcfg_wr_decode.sv
// Module: write decoder. Turns address and byte strobes into per-word
// hits, a 32-bit bit mask, the soft-reset request and the lock state.
// Assumes the enable value given is the one held before this write.
module tcfg_wr_decode
    import tcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    input  logic              enable_q,
    output logic [NREG-1:0]   hit,
    output logic [31:0]       bmask,
    output logic              swrst_req,
    output logic              prot_open
);
    // Per-word address hit for a write
    for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
        assign hit[gi] = wr_en && (addr == ADDR_W'(gi));
    end

    // Byte strobe expansion to a bit mask
    for (genvar gb = 0; gb < 4; gb++) begin : g_mask
        assign bmask[gb*8 +: 8] = {8{be[gb]}};
    end

    // Soft reset needs byte 0 and bit 0 of a control write
    assign swrst_req = hit[A_CTRL] && be[0] && wdata[B_SWRST];

    // Locked fields open only while the prior enable is 0
    assign prot_open = !enable_q;
endmodule

// File: rtl/tcfg_prot_reg.sv
// Module: lockable configuration word. Stores only the bits in WMASK,
// updates strobed bits on an accepted write, returns to RESET on clear.
// Assumes the caller folds the lock decision into we.
module tcfg_prot_reg #(
    parameter logic [31:0] WMASK = 32'h0000_00FF,
    parameter logic [31:0] RESET = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        we,
    input  logic [31:0] bmask,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    localparam logic [31:0] RST_M = RESET & WMASK;
    logic [31:0] upd;

    // Bits this write may change
    assign upd = bmask & WMASK;

    // Storage with reset, clear and masked write
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_M;
        else if (clr) q <= RST_M;
        else if (we)  q <= (q & ~upd) | (wdata & upd);
    end
endmodule

// File: rtl/tcfg_mode_reg.sv
// Module: counter-width field. Takes a new code only when it is legal.
// Assumes the caller gates we with the lock and the byte-0 strobe.
module tcfg_mode_reg
    import tcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       we,
    input  logic [1:0] wcode,
    output cnt_mode_e  mode
);
    logic legal;

    // Code 3 is not a width and is refused
    assign legal = (wcode != MODE_BAD);

    // Mode storage, default 16-bit
    always_ff @(posedge clk) begin
        if (!rst_n)            mode <= MODE_16;
        else if (clr)          mode <= MODE_16;
        else if (we && legal)  mode <= cnt_mode_e'(wcode);
    end
endmodule

// File: rtl/tcfg_setclr_reg.sv
// Module: bits driven through a set address and a clear address.
// Assumes only one of set_we and clr_we is high in any cycle.
module tcfg_setclr_reg #(
    parameter int unsigned NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [NB-1:0] bits_in,
    output logic [NB-1:0] q
);
    logic [NB-1:0] set_m;
    logic [NB-1:0] clr_m;

    // Ones in the written data select which bits move
    assign set_m = set_we ? bits_in : '0;
    assign clr_m = clr_we ? bits_in : '0;

    // Bit storage with set and clear
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else           q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/tcfg_rd_mux.sv
// Module: registered read port. Selects the addressed word on rd_en and
// returns 0 for unmapped addresses. Holds its output when idle.
module tcfg_rd_mux #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NW     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NW-1:0][31:0]  words,
    output logic [31:0]          rdata
);
    logic [31:0] sel;

    // Word select, zero outside the map
    always_comb begin
        sel = '0;
        for (int i = 0; i < NW; i++) begin
            if (addr == ADDR_W'(i)) sel = words[i];
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel;
    end
endmodule

// File: rtl/tcfg_bank.sv
// Module: configuration bank top. Holds the control, drive, waveform and
// event words plus the one-shot/direction pair, applies the write lock
// and soft reset, and drives the live configuration outputs.
// Assumes NCH <= 8 and PW <= 4 so the fields stay in their byte slots.
module tcfg_bank
    import tcfg_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned PW     = 3,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              cfg_enable,
    output logic [1:0]        cfg_mode,
    output logic [PW-1:0]     cfg_presc,
    output logic [1:0]        cfg_presync,
    output logic [NCH-1:0]    cfg_capten,
    output logic [NCH-1:0]    cfg_inven,
    output logic [1:0]        cfg_wavegen,
    output logic [2:0]        cfg_evact,
    output logic              cfg_evin_en,
    output logic              cfg_evout_en,
    output logic              cfg_oneshot,
    output logic              cfg_dir
);
    localparam logic [31:0] M_PRESC = 32'(((64'd1 << PW) - 1) << B_PRESC);
    localparam logic [31:0] M_SYNC  = 32'(64'd3 << B_SYNC);
    localparam logic [31:0] M_CAPT  = 32'(((64'd1 << NCH) - 1) << B_CAPT);
    localparam logic [31:0] M_CTRL  = M_PRESC | M_SYNC | M_CAPT;
    localparam logic [31:0] M_DRIVE = 32'((64'd1 << NCH) - 1);
    localparam logic [31:0] M_WAVE  = 32'h0000_0003;
    localparam logic [31:0] M_EVENT = 32'h0000_0037;

    logic [NREG-1:0]       hit;
    logic [31:0]           bmask;
    logic                  swrst;
    logic                  prot_open;
    logic                  en_q;
    cnt_mode_e             mode_q;
    logic [31:0]           ctrl_q, drive_q, wave_q, event_q;
    logic [1:0]            cb_q;
    logic [NREG-1:0][31:0] words;

    tcfg_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
        .enable_q(en_q), .hit(hit), .bmask(bmask),
        .swrst_req(swrst), .prot_open(prot_open)
    );

    // Enable bit: never locked, cleared by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= 1'b0;
        else if (swrst)               en_q <= 1'b0;
        else if (hit[A_CTRL] && be[0]) en_q <= wdata[B_EN];
    end

    tcfg_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .we(hit[A_CTRL] && prot_open && be[0]),
        .wcode(wdata[B_MODE +: 2]), .mode(mode_q)
    );

    tcfg_prot_reg #(.WMASK(M_CTRL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .we(hit[A_CTRL] && prot_open), .bmask(bmask), .wdata(wdata), .q(ctrl_q)
    );

    tcfg_prot_reg #(.WMASK(M_DRIVE)) u_drive (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .we(hit[A_DRIVE] && prot_open), .bmask(bmask), .wdata(wdata), .q(drive_q)
    );

    tcfg_prot_reg #(.WMASK(M_WAVE)) u_wave (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .we(hit[A_WAVE] && prot_open), .bmask(bmask), .wdata(wdata), .q(wave_q)
    );

    tcfg_prot_reg #(.WMASK(M_EVENT)) u_event (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .we(hit[A_EVENT] && prot_open), .bmask(bmask), .wdata(wdata), .q(event_q)
    );

    tcfg_setclr_reg #(.NB(2)) u_cb (
        .clk(clk), .rst_n(rst_n), .clr(swrst),
        .set_we(hit[A_CBSET] && be[0]), .clr_we(hit[A_CBCLR] && be[0]),
        .bits_in(wdata[1:0]), .q(cb_q)
    );

    // Read-back words; soft-reset bit always reads 0
    always_comb begin
        words          = '0;
        words[A_CTRL]  = ctrl_q | (32'(mode_q) << B_MODE) | (32'(en_q) << B_EN);
        words[A_DRIVE] = drive_q;
        words[A_WAVE]  = wave_q;
        words[A_EVENT] = event_q;
        words[A_CBSET] = {30'd0, cb_q};
        words[A_CBCLR] = {30'd0, cb_q};
    end

    tcfg_rd_mux #(.ADDR_W(ADDR_W), .NW(NREG)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .words(words), .rdata(rdata)
    );

    // Live configuration to the counter core
    assign cfg_enable   = en_q;
    assign cfg_mode     = mode_q;
    assign cfg_presc    = ctrl_q[B_PRESC +: PW];
    assign cfg_presync  = ctrl_q[B_SYNC +: 2];
    assign cfg_capten   = ctrl_q[B_CAPT +: NCH];
    assign cfg_inven    = drive_q[NCH-1:0];
    assign cfg_wavegen  = wave_q[1:0];
    assign cfg_evact    = event_q[2:0];
    assign cfg_evin_en  = event_q[4];
    assign cfg_evout_en = event_q[5];
    assign cfg_oneshot  = cb_q[0];
    assign cfg_dir      = cb_q[1];
endmodule

// File: rtl/tcfg_bank_chk.sv
// Module: property checker for tcfg_bank, attached by bind. Watches only
// the ports of the bank.
module tcfg_bank_chk
    import tcfg_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned PW     = 3,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        be,
    input logic [31:0]       wdata,
    input logic              cfg_enable,
    input logic [1:0]        cfg_mode,
    input logic [PW-1:0]     cfg_presc,
    input logic [1:0]        cfg_presync,
    input logic [NCH-1:0]    cfg_capten,
    input logic [NCH-1:0]    cfg_inven,
    input logic [1:0]        cfg_wavegen,
    input logic [2:0]        cfg_evact,
    input logic              cfg_evin_en,
    input logic              cfg_evout_en,
    input logic              cfg_oneshot,
    input logic              cfg_dir
);
    logic ctrl_b0;
    logic swr;
    assign ctrl_b0 = wr_en && (addr == ADDR_W'(A_CTRL)) && be[0];
    assign swr     = ctrl_b0 && wdata[B_SWRST];

    assert_swrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (!cfg_enable && cfg_mode == 2'd0 && cfg_presc == '0 &&
                 cfg_presync == 2'd0 && cfg_capten == '0 && cfg_inven == '0 &&
                 cfg_wavegen == 2'd0 && cfg_evact == 3'd0 && !cfg_evin_en &&
                 !cfg_evout_en && !cfg_oneshot && !cfg_dir));

    assert_locked_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !swr) |=> $stable({cfg_mode, cfg_presc, cfg_presync,
            cfg_capten, cfg_inven, cfg_wavegen, cfg_evact, cfg_evin_en, cfg_evout_en}));

    assert_disable_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && ctrl_b0 && !wdata[B_EN]) |=> !cfg_enable);

    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_enable));

    assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode != 2'd3);

    assert_set_oneshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_CBSET) && be[0] && wdata[0]) |=> cfg_oneshot);
endmodule

bind tcfg_bank tcfg_bank_chk #(.NCH(NCH), .PW(PW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tcfg_bank_tb.sv
`timescale 1ns/1ps
module tcfg_bank_tb;
    localparam int unsigned NCH = 2, PW = 3, ADDR_W = 4;
    localparam logic [31:0] P_CTRL = 32'h0003_0370;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0] be = '0;
    logic [31:0] wdata = '0, rdata;
    logic cfg_enable, cfg_evin_en, cfg_evout_en, cfg_oneshot, cfg_dir;
    logic [1:0] cfg_mode, cfg_presync, cfg_wavegen;
    logic [PW-1:0] cfg_presc;
    logic [NCH-1:0] cfg_capten, cfg_inven;
    logic [2:0] cfg_evact;

    int checks = 0, errors = 0;
    logic [31:0] sh_ctrl, sh_drive, sh_wave, sh_event;
    logic [1:0] sh_cb;

    always #2.5 clk = ~clk;

    tcfg_bank #(.NCH(NCH), .PW(PW), .ADDR_W(ADDR_W)) u_dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bmk(logic [3:0] b);
        return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    endfunction

    // Reference update of the shadow words from the requirements
    task automatic model(int a, logic [31:0] d, logic [3:0] b);
        logic [31:0] m, nw;
        bit open;
        open = !sh_ctrl[1];
        m = bmk(b);
        if (a == 0 && b[0] && d[0]) begin
            sh_ctrl = 0; sh_drive = 0; sh_wave = 0; sh_event = 0; sh_cb = 0;
        end else if (a == 0) begin
            nw = sh_ctrl;
            if (open) begin
                nw = (nw & ~(m & P_CTRL)) | (d & m & P_CTRL);
                if (b[0] && d[3:2] != 2'd3) nw[3:2] = d[3:2];
            end
            if (b[0]) nw[1] = d[1];
            sh_ctrl = nw;
        end else if (a == 1 && open) sh_drive = (sh_drive & ~(m & 32'h3)) | (d & m & 32'h3);
        else if (a == 2 && open) sh_wave = (sh_wave & ~(m & 32'h3)) | (d & m & 32'h3);
        else if (a == 3 && open) sh_event = (sh_event & ~(m & 32'h37)) | (d & m & 32'h37);
        else if (a == 4 && b[0]) sh_cb = sh_cb | d[1:0];
        else if (a == 5 && b[0]) sh_cb = sh_cb & ~d[1:0];
    endtask

    task automatic wr(int a, logic [31:0] d, logic [3:0] b);
        @(negedge clk);
        wr_en = 1; addr = ADDR_W'(a); wdata = d; be = b;
        @(negedge clk);
        wr_en = 0;
        model(a, d, b);
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    function automatic logic [31:0] sh_word(int a);
        case (a)
            0: return sh_ctrl;
            1: return sh_drive;
            2: return sh_wave;
            3: return sh_event;
            4, 5: return {30'd0, sh_cb};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_outs(string tag);
        check({tag, " outputs"},
              {8'd0, cfg_enable, cfg_mode, cfg_presc, cfg_presync, cfg_capten,
               cfg_inven, cfg_wavegen, cfg_evact, cfg_evin_en, cfg_evout_en,
               cfg_oneshot, cfg_dir},
              {8'd0, sh_ctrl[1], sh_ctrl[3:2], sh_ctrl[6:4], sh_ctrl[9:8],
               sh_ctrl[17:16], sh_drive[1:0], sh_wave[1:0], sh_event[2:0],
               sh_event[4], sh_event[5], sh_cb[0], sh_cb[1]});
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        sh_ctrl = 0; sh_drive = 0; sh_wave = 0; sh_event = 0; sh_cb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R1 reset word", d, 32'd0);
        end
        check_outs("R1");

        // R2/R3/R8/R11: byte-strobe sweep over locked words in both enable states
        for (int en = 0; en < 2; en++) begin
            wr(0, 32'h1, 4'h1);
            if (en == 1) wr(0, 32'h2, 4'h1);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [31:0] p;
                    p = 32'h5A5A_F00F ^ {4{8'(b * 37 + a * 11)}};
                    if (a == 0) begin
                        p[0] = 1'b0;
                        p[1] = en[0];
                    end
                    wr(a, p, 4'(b));
                    rd(a, d);
                    check(en == 0 ? "R2 open write" : "R3 locked write R11", d, sh_word(a));
                    check_outs(en == 0 ? "R2 R8" : "R3");
                end
            end
        end

        // R4: enable set in the same access as locked fields
        wr(0, 32'h1, 4'h1);
        wr(0, 32'h0003_0356, 4'hF);
        rd(0, d);
        check("R4 enable plus fields", d, 32'h0003_0356);
        check("R4 outputs", {28'd0, cfg_enable, cfg_presc}, {28'd0, 1'b1, 3'd5});

        // R5: clearing enable leaves locked fields alone
        wr(0, 32'h0000_0008, 4'hF);
        rd(0, d);
        check("R5 disable only", d, 32'h0003_0354);
        check_outs("R5");

        // R6: enable untouched without byte 0, written with byte 0
        wr(0, 32'h0000_0002, 4'hE);
        check("R6 no byte0", {31'd0, cfg_enable}, 32'd0);
        wr(0, 32'h0000_0002, 4'h1);
        check("R6 set enable", {31'd0, cfg_enable}, 32'd1);

        // R10: set/clear pair in both enable states
        for (int en = 1; en >= 0; en--) begin
            wr(0, 32'(en) << 1, 4'h1);
            for (int v = 0; v < 4; v++) begin
                wr(4, 32'(v), 4'h1);
                rd(4, d);
                check("R10 set", d, sh_word(4));
                wr(5, 32'(v ^ 1), 4'h1);
                rd(5, d);
                check("R10 clear", d, sh_word(5));
                check_outs("R10");
            end
            wr(4, 32'h3, 4'h2);
            check_outs("R10 no byte0");
        end

        // R7: soft reset overrides other bits, including enable
        wr(1, 32'h3, 4'hF);
        wr(4, 32'h3, 4'h1);
        wr(0, 32'h0003_0377, 4'hF);
        check_outs("R7 before");
        wr(0, 32'h0000_0003, 4'h1);
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R7 soft reset", d, 32'd0);
        end
        check_outs("R7");

        // R9: unmapped addresses read 0 and ignore writes
        wr(1, 32'h2, 4'hF);
        for (int a = 6; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFE, 4'hF);
            rd(a, d);
            check("R9 unmapped", d, 32'd0);
        end
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R9 mapped intact", d, sh_word(a));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule